// File: doc/BRIEF.md
# Paged Address Translation Mapper

This block widens a 16-bit CPU address into a physical address by page lookup. The top four address bits pick one of sixteen frame entries held in registers. The chosen 12-bit entry takes the place of those four bits. The low twelve bits carry through untouched, so each page covers 4 KB. Address decoding further down the chip works on the translated output rather than on the raw CPU address. Any region of memory can therefore be reached through whichever CPU page points at it.

Software loads the table through a narrow synchronous write port. One chip select stores the 8-bit write data into the entry named by an index input. A second chip select loads a one-bit control word that turns translation on. While translation is off, the block applies a fixed identity map. The page number stays in physical bits 15:12 and everything above is zero. Each entry and the control word can be read back combinationally. No access protection is applied to any page.

Top module: `pgmap_top`

## Requirements
- R1: While `rst` is high at a clock edge, the enable bit and all sixteen entries clear to zero, so after reset `ctl_rdata` is 0, every `rd_entry` is 0 and translation is in identity mode.
- R2: With enable 0, `phys_addr` equals `{8'h00, cpu_addr}` whatever the table holds.
- R3: With enable 1, `phys_addr[23:12]` equals entry number `cpu_addr[15:12]` and `phys_addr[11:0]` equals `cpu_addr[11:0]`.
- R4: A clock edge with `tbl_cs` high stores `{4'h0, wr_data}` into entry `tbl_idx`; the new value is visible at `rd_entry` and `phys_addr` right after that edge, and no other entry changes.
- R5: Bits 11:8 of every entry are always zero, so `phys_addr[23:20]` is always zero and the reachable space is 20 bits.
- R6: A clock edge with `ctl_cs` high loads the enable bit from `wr_data[0]`; `wr_data[7:1]` is ignored, and `ctl_rdata` reads as `{7'b0, enable}`.
- R7: With its chip select low, neither the table nor the enable bit changes, whatever `wr_data` and `tbl_idx` do.
- R8: With both chip selects high in the same cycle, both writes take effect from the same `wr_data`.
- R9: Entries written while translation is off are kept and are used as soon as translation is turned on.
- R10: Translation is combinational, so `phys_addr` follows a change of `cpu_addr` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address to translate |
| phys_addr | output | 24 | Translated physical address |
| tbl_cs | input | 1 | Chip select that writes a table entry |
| tbl_idx | input | 4 | Entry number for a table write |
| ctl_cs | input | 1 | Chip select that writes the control word |
| wr_data | input | 8 | Write data shared by both chip selects |
| rd_idx | input | 4 | Entry number for readback |
| rd_entry | output | 12 | Content of entry `rd_idx` |
| ctl_rdata | output | 8 | Control word readback, enable in bit 0 |

## Verification
The hardest case to reach is a table that holds real frames while the enable bit is off. Those frames are hidden until the enable bit is set. The stimulus writes entries in identity mode and confirms the output ignores them. It then raises the enable bit alone and confirms the stored frames show up. It also drives both chip selects with one data byte in the same cycle. That one cycle shows whether the two write paths interfere with each other.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

    localparam int CPU_AW    = 16;
    localparam int PAGE_W    = 4;
    localparam int FRAME_W   = 12;
    localparam int WDATA_W   = 8;
    localparam int CTL_W     = 8;
    localparam int OFFS_W    = CPU_AW - PAGE_W;
    localparam int PHYS_AW   = FRAME_W + OFFS_W;
    localparam int NUM_PAGES = 1 << PAGE_W;
    localparam int FRAME_PAD = FRAME_W - WDATA_W;
    localparam int IDENT_PAD = FRAME_W - PAGE_W;

    typedef logic [PAGE_W-1:0]  page_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [OFFS_W-1:0]  offs_t;
    typedef logic [WDATA_W-1:0] wdata_t;

    typedef struct packed {
        page_t page;
        offs_t offs;
    } vaddr_t;

    typedef struct packed {
        frame_t frame;
        offs_t  offs;
    } paddr_t;

    typedef enum logic {
        XL_IDENTITY = 1'b0,
        XL_PAGED    = 1'b1
    } xl_mode_e;

    function automatic frame_t frame_from_data(input wdata_t d);
        return {{FRAME_PAD{1'b0}}, d};
    endfunction

    function automatic frame_t identity_frame(input page_t p);
        return {{IDENT_PAD{1'b0}}, p};
    endfunction

endpackage

// File: rtl/pgmap_table.sv
module pgmap_table
    import pgmap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  page_t  wr_idx,
    input  wdata_t wr_data,
    input  page_t  lk_idx,
    output frame_t lk_frame,
    input  page_t  rd_idx,
    output frame_t rd_frame
);

    frame_t ent_q [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (wr_en && (wr_idx == page_t'(g))) begin
                ent_q[g] <= frame_from_data(wr_data);
            end
        end

        AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && (wr_idx == page_t'(g))) |=> $stable(ent_q[g])); // R7

        AST_ENTRY_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
            ent_q[g][FRAME_W-1:WDATA_W] == '0); // R5
    end

    assign lk_frame = ent_q[lk_idx];
    assign rd_frame = ent_q[rd_idx];

    AST_ENTRY_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ent_q[$past(wr_idx)] == frame_from_data($past(wr_data))); // R4

endmodule

// File: rtl/pgmap_ctrl.sv
module pgmap_ctrl
    import pgmap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  logic     wr_bit,
    output xl_mode_e mode
);

    xl_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= XL_IDENTITY;
        end else if (wr_en) begin
            mode_q <= wr_bit ? XL_PAGED : XL_IDENTITY;
        end
    end

    assign mode = mode_q;

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mode_q == XL_PAGED) == $past(wr_bit)); // R6

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mode_q)); // R7

    AST_MODE_RESET: assert property (@(posedge clk)
        rst |=> mode_q == XL_IDENTITY); // R1

endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
    import pgmap_pkg::*;
(
    input  xl_mode_e mode,
    input  vaddr_t   va,
    input  frame_t   tbl_frame,
    output paddr_t   pa
);

    always_comb begin
        pa.offs = va.offs;
        unique case (mode)
            XL_PAGED:    pa.frame = tbl_frame;
            XL_IDENTITY: pa.frame = identity_frame(va.page);
            default:     pa.frame = identity_frame(va.page);
        endcase
    end

endmodule

// File: rtl/pgmap_top.sv
module pgmap_top
    import pgmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CPU_AW-1:0]   cpu_addr,
    output logic [PHYS_AW-1:0]  phys_addr,
    input  logic                tbl_cs,
    input  logic [PAGE_W-1:0]   tbl_idx,
    input  logic                ctl_cs,
    input  logic [WDATA_W-1:0]  wr_data,
    input  logic [PAGE_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0]  rd_entry,
    output logic [CTL_W-1:0]    ctl_rdata
);

    vaddr_t   va;
    paddr_t   pa;
    frame_t   lk_frame;
    xl_mode_e mode;

    assign va = vaddr_t'(cpu_addr);

    pgmap_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_cs),
        .wr_idx   (tbl_idx),
        .wr_data  (wr_data),
        .lk_idx   (va.page),
        .lk_frame (lk_frame),
        .rd_idx   (rd_idx),
        .rd_frame (rd_entry)
    );

    pgmap_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctl_cs),
        .wr_bit (wr_data[0]),
        .mode   (mode)
    );

    pgmap_xlate u_xlate (
        .mode      (mode),
        .va        (va),
        .tbl_frame (lk_frame),
        .pa        (pa)
    );

    assign phys_addr = pa;
    assign ctl_rdata = {{(CTL_W-1){1'b0}}, (mode == XL_PAGED)};

    AST_IDENTITY_MAP: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[0] == 1'b0) |-> phys_addr == {{(PHYS_AW-CPU_AW){1'b0}}, cpu_addr}); // R2

    AST_PAGED_MAP: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[0] && rd_idx == cpu_addr[CPU_AW-1:OFFS_W])
        |-> phys_addr[PHYS_AW-1:OFFS_W] == rd_entry); // R3

    AST_PHYS_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        phys_addr[PHYS_AW-1:PHYS_AW-FRAME_PAD] == '0); // R5

    AST_RESET_READBACK: assert property (@(posedge clk)
        rst |=> (ctl_rdata == '0) && (rd_entry == '0)); // R1

endmodule

// File: tb/pgmap_top_tb_top.sv
module pgmap_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [23:0] phys_addr;
    logic        tbl_cs;
    logic [3:0]  tbl_idx;
    logic        ctl_cs;
    logic [7:0]  wr_data;
    logic [3:0]  rd_idx;
    logic [11:0] rd_entry;
    logic [7:0]  ctl_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pgmap_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .phys_addr (phys_addr),
        .tbl_cs    (tbl_cs),
        .tbl_idx   (tbl_idx),
        .ctl_cs    (ctl_cs),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_entry  (rd_entry),
        .ctl_rdata (ctl_rdata)
    );

    // {enable, cpu address, expected physical address}; entry i holds {i, 15-i}
    localparam logic [40:0] VEC [8] = '{
        {1'b1, 16'h0123, 24'h00F123},
        {1'b1, 16'h5ABC, 24'h05AABC},
        {1'b1, 16'hA000, 24'h0A5000},
        {1'b1, 16'hFFFF, 24'h0F0FFF},
        {1'b1, 16'h3456, 24'h03C456},
        {1'b1, 16'hC001, 24'h0C3001},
        {1'b0, 16'h5ABC, 24'h005ABC},
        {1'b0, 16'hFFFF, 24'h00FFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_tbl(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        tbl_cs = 1'b1; tbl_idx = idx; wr_data = d;
        @(negedge clk);
        tbl_cs = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk);
        ctl_cs = 1'b1; wr_data = d;
        @(negedge clk);
        ctl_cs = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cpu_addr = 16'h7123; tbl_cs = 1'b0; tbl_idx = '0;
        ctl_cs = 1'b0; wr_data = '0; rd_idx = '0;
        do_reset();

        // R1: reset state
        check("R1 ctl", 32'(ctl_rdata), 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i); #1;
            check("R1 entry", 32'(rd_entry), 32'h0);
        end
        check("R1 identity", 32'(phys_addr), 32'h007123);

        // load table, entry i = {i, 15-i}
        for (int i = 0; i < 16; i++) wr_tbl(4'(i), {4'(i), 4'(15 - i)});
        rd_idx = 4'h5; #1;
        check("R4 readback", 32'(rd_entry), 32'h05A);

        // R2/R3 vector walk
        for (int v = 0; v < 8; v++) begin
            if (ctl_rdata[0] != VEC[v][40]) wr_ctl({7'b0, VEC[v][40]});
            cpu_addr = VEC[v][39:24]; #1;
            check(VEC[v][40] ? "R3 paged" : "R2 identity", 32'(phys_addr), 32'(VEC[v][23:0]));
        end

        // R6: upper control bits ignored
        wr_ctl(8'hFE);
        check("R6 ctl bit0 zero", 32'(ctl_rdata), 32'h00);
        wr_ctl(8'hFF);
        check("R6 ctl bit0 one", 32'(ctl_rdata), 32'h01);

        // R10: combinational path, no clock edge
        @(negedge clk);
        cpu_addr = 16'hA123; #1;
        check("R10 comb a", 32'(phys_addr), 32'h0A5123);
        cpu_addr = 16'h5123; #1;
        check("R10 comb b", 32'(phys_addr), 32'h05A123);

        // R4: single write, neighbours untouched; R5 upper zero
        wr_tbl(4'h9, 8'hFF);
        rd_idx = 4'h9; #1;
        check("R5 entry pad", 32'(rd_entry), 32'h0FF);
        rd_idx = 4'h8; #1;
        check("R4 neighbour 8", 32'(rd_entry), 32'h087);
        rd_idx = 4'hA; #1;
        check("R4 neighbour A", 32'(rd_entry), 32'h0A5);
        cpu_addr = 16'h9FFF; #1;
        check("R5 phys top", 32'(phys_addr), 32'h0FFFFF);

        // R7: chip selects low, inputs wiggle
        @(negedge clk);
        tbl_idx = 4'h3; wr_data = 8'h00;
        @(negedge clk);
        wr_data = 8'h55;
        @(negedge clk);
        rd_idx = 4'h3; #1;
        check("R7 table hold", 32'(rd_entry), 32'h03C);
        check("R7 ctl hold", 32'(ctl_rdata), 32'h01);

        // R8: both chip selects in one cycle
        wr_ctl(8'h00);
        @(negedge clk);
        tbl_cs = 1'b1; ctl_cs = 1'b1; tbl_idx = 4'h2; wr_data = 8'h81;
        @(negedge clk);
        tbl_cs = 1'b0; ctl_cs = 1'b0;
        rd_idx = 4'h2; #1;
        check("R8 entry", 32'(rd_entry), 32'h081);
        check("R8 ctl", 32'(ctl_rdata), 32'h01);
        cpu_addr = 16'h2345; #1;
        check("R8 phys", 32'(phys_addr), 32'h081345);

        // R9: write while disabled, then enable
        wr_ctl(8'h00);
        wr_tbl(4'h7, 8'h77);
        cpu_addr = 16'h7ABC; #1;
        check("R9 hidden", 32'(phys_addr), 32'h007ABC);
        wr_ctl(8'h01);
        #1;
        check("R9 revealed", 32'(phys_addr), 32'h077ABC);

        // R1: mid-run reset clears everything
        do_reset();
        #1;
        check("R1 rerst ctl", 32'(ctl_rdata), 32'h0);
        rd_idx = 4'h7; #1;
        check("R1 rerst entry", 32'(rd_entry), 32'h0);
        check("R1 rerst phys", 32'(phys_addr), 32'h007ABC);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule